// File: doc/BRIEF.md
# Load-Indexed Stride Prefetch Predictor

This block watches the stream of executed loads and learns, for each load instruction separately, whether that load walks memory with a fixed step. Each load presents its program counter and its effective address. A direct-mapped table, indexed by low bits of the program counter, holds one record per tracked load: a tag made from the upper program-counter bits, the address the load last used, a signed step, and a two-bit confidence state.

On every load the record is read, compared and rewritten in the same cycle. A load whose program counter does not match the stored tag takes over the slot and starts from scratch. A load that hits checks whether its address equals the stored address plus the stored step, and a four-state confidence machine decides the new state and whether the step is relearned. When the new state is the confident one, the block raises a one-cycle request for the address one step ahead. Sending that request into the memory system and filtering duplicates is left to the surrounding logic.

Top module: `stride_prefetch_table`

## Requirements
- R1: While and after reset every slot is empty and `pf_valid` is low; the first load of any program counter after reset is a miss.
- R2: A load whose slot is empty or holds a different tag rewrites the slot with the new tag, its address as last address, a step of zero and the state Fresh, and raises no request.
- R3: A hitting load is a correct prediction exactly when its address equals the stored last address plus the stored step, modulo 2^ADDR_W; otherwise it is a wrong prediction, and the observed step is the address minus the stored last address.
- R4: From Fresh, a correct prediction moves to Locked; a wrong one moves to Tentative and stores the observed step.
- R5: From Tentative, a correct prediction moves to Locked; a wrong one moves to Silent and stores the observed step.
- R6: From Locked, a correct prediction stays in Locked; a wrong one returns to Fresh and keeps the stored step.
- R7: From Silent, a correct prediction moves to Tentative; a wrong one stays in Silent and stores the observed step.
- R8: Every load, hit or miss, writes its own address as the slot's last address.
- R9: A load whose updated state is Locked makes `pf_valid` high for exactly the one cycle after the load's clock edge, with `pf_addr` equal to the load address plus the stored step; no other load and no idle cycle raises `pf_valid`.
- R10: The step is a two's-complement value of ADDR_W bits, so descending and address-wrapping patterns are learned and predicted like ascending ones.
- R11: The slot is selected by program-counter bits [PC_SKIP+IDX_W-1:PC_SKIP] and the tag is all bits above them; two loads sharing a slot but differing in tag evict each other.
- R12: A cycle with `ld_valid` low changes no slot, so a load's learned state survives any number of idle cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ld_valid | input | 1 | A load is presented this cycle |
| ld_pc | input | PC_W | Program counter of the load |
| ld_addr | input | ADDR_W | Effective address of the load |
| pf_valid | output | 1 | One-cycle prefetch request strobe |
| pf_addr | output | ADDR_W | Predicted next address of the load |

## Verification
The hardest situations to reach are the Silent state and its exits, since a load only gets there after two consecutive wrong predictions with different steps, and the Locked-to-Fresh return that must keep an old step which only a later correct prediction reveals. Directed load sequences walk one program counter through every arc of the confidence machine while predicting each request address by hand. A long pseudo-random phase then mixes eight program counters that share four slots, with occasional step changes and jumps, and compares every output cycle against a table model kept in the bench, so evictions interleave with every state.

// File: rtl/spf_pkg.sv
package spf_pkg;

    // Confidence of a tracked load.
    typedef enum logic [1:0] {
        CF_FRESH     = 2'd0,
        CF_TENTATIVE = 2'd1,
        CF_LOCKED    = 2'd2,
        CF_SILENT    = 2'd3
    } conf_e;

    // Result of one confidence step.
    typedef struct packed {
        conf_e next;
        logic  relearn;
    } conf_step_t;

    function automatic conf_step_t conf_step(input conf_e cur, input logic correct);
        conf_step_t r;
        r.next    = cur;
        r.relearn = 1'b0;
        unique case (cur)
            CF_FRESH: begin
                r.next    = correct ? CF_LOCKED : CF_TENTATIVE;
                r.relearn = ~correct;
            end
            CF_TENTATIVE: begin
                r.next    = correct ? CF_LOCKED : CF_SILENT;
                r.relearn = ~correct;
            end
            CF_LOCKED: begin
                r.next    = correct ? CF_LOCKED : CF_FRESH;
                r.relearn = 1'b0;
            end
            CF_SILENT: begin
                r.next    = correct ? CF_TENTATIVE : CF_SILENT;
                r.relearn = ~correct;
            end
            default: begin
                r.next    = CF_FRESH;
                r.relearn = 1'b0;
            end
        endcase
        return r;
    endfunction

    function automatic logic conf_issues(input conf_e st);
        return st == CF_LOCKED;
    endfunction

endpackage

// File: rtl/spf_index_split.sv
module spf_index_split #(
    parameter int PC_W    = 32,
    parameter int PC_SKIP = 2,
    parameter int IDX_W   = 6,
    parameter int TAG_W   = PC_W - PC_SKIP - IDX_W
) (
    input  logic [PC_W-1:0]  pc,
    output logic [IDX_W-1:0] idx,
    output logic [TAG_W-1:0] tag
);

    logic [PC_SKIP-1:0] unused_low;

    always_comb begin
        idx        = pc[PC_SKIP +: IDX_W];
        tag        = pc[PC_W-1 -: TAG_W];
        unused_low = pc[PC_SKIP-1:0];
    end

endmodule

// File: rtl/spf_table.sv
module spf_table
    import spf_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int TAG_W   = 24,
    parameter int ADDR_W  = 32,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    // read port
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [ADDR_W-1:0] rd_prev,
    output logic [ADDR_W-1:0] rd_stride,
    output conf_e             rd_state,
    // write port
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [ADDR_W-1:0] wr_prev,
    input  logic [ADDR_W-1:0] wr_stride,
    input  conf_e             wr_state
);

    logic              slot_valid  [ENTRIES];
    logic [TAG_W-1:0]  slot_tag    [ENTRIES];
    logic [ADDR_W-1:0] slot_prev   [ENTRIES];
    logic [ADDR_W-1:0] slot_stride [ENTRIES];
    conf_e             slot_state  [ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
        logic sel;
        assign sel = wr_en && (wr_idx == IDX_W'(e));

        always_ff @(posedge clk) begin
            if (rst) begin
                slot_valid[e] <= 1'b0;
            end else if (sel) begin
                slot_valid[e] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                slot_tag[e]    <= '0;
                slot_prev[e]   <= '0;
                slot_stride[e] <= '0;
                slot_state[e]  <= CF_FRESH;
            end else if (sel) begin
                slot_tag[e]    <= wr_tag;
                slot_prev[e]   <= wr_prev;
                slot_stride[e] <= wr_stride;
                slot_state[e]  <= wr_state;
            end
        end
    end

    always_comb begin
        rd_valid  = slot_valid[rd_idx];
        rd_tag    = slot_tag[rd_idx];
        rd_prev   = slot_prev[rd_idx];
        rd_stride = slot_stride[rd_idx];
        rd_state  = slot_state[rd_idx];
    end

endmodule

// File: rtl/spf_update.sv
module spf_update
    import spf_pkg::*;
#(
    parameter int TAG_W  = 24,
    parameter int ADDR_W = 32
) (
    input  logic [TAG_W-1:0]  lk_tag,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic              rd_valid,
    input  logic [TAG_W-1:0]  rd_tag,
    input  logic [ADDR_W-1:0] rd_prev,
    input  logic [ADDR_W-1:0] rd_stride,
    input  conf_e             rd_state,
    output logic              hit,
    output logic [ADDR_W-1:0] nx_prev,
    output logic [ADDR_W-1:0] nx_stride,
    output conf_e             nx_state,
    output logic              pf_fire,
    output logic [ADDR_W-1:0] pf_target
);

    logic [ADDR_W-1:0] predicted;
    logic [ADDR_W-1:0] observed;
    logic              correct;
    conf_step_t        step;

    always_comb begin
        hit       = rd_valid && (rd_tag == lk_tag);
        predicted = rd_prev + rd_stride;
        observed  = cur_addr - rd_prev;
        correct   = (cur_addr == predicted);
        step      = conf_step(rd_state, correct);

        nx_prev   = cur_addr;
        if (hit) begin
            nx_stride = step.relearn ? observed : rd_stride;
            nx_state  = step.next;
            pf_fire   = conf_issues(step.next);
        end else begin
            nx_stride = '0;
            nx_state  = CF_FRESH;
            pf_fire   = 1'b0;
        end
        pf_target = cur_addr + nx_stride;
    end

endmodule

// File: rtl/stride_prefetch_table.sv
module stride_prefetch_table
    import spf_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int ADDR_W  = 32,
    parameter int ENTRIES = 64,
    parameter int PC_SKIP = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_valid,
    input  logic [PC_W-1:0]   ld_pc,
    input  logic [ADDR_W-1:0] ld_addr,
    output logic              pf_valid,
    output logic [ADDR_W-1:0] pf_addr
);

    localparam int IDX_W = $clog2(ENTRIES);
    localparam int TAG_W = PC_W - PC_SKIP - IDX_W;

    logic [IDX_W-1:0]  lk_idx;
    logic [TAG_W-1:0]  lk_tag;
    logic              rd_valid;
    logic [TAG_W-1:0]  rd_tag;
    logic [ADDR_W-1:0] rd_prev;
    logic [ADDR_W-1:0] rd_stride;
    conf_e             rd_state;
    logic              lk_hit;
    logic [ADDR_W-1:0] nx_prev;
    logic [ADDR_W-1:0] nx_stride;
    conf_e             nx_state;
    logic              pf_fire;
    logic [ADDR_W-1:0] pf_target;

    spf_index_split #(
        .PC_W    (PC_W),
        .PC_SKIP (PC_SKIP),
        .IDX_W   (IDX_W),
        .TAG_W   (TAG_W)
    ) u_split (
        .pc  (ld_pc),
        .idx (lk_idx),
        .tag (lk_tag)
    );

    spf_table #(
        .ENTRIES (ENTRIES),
        .TAG_W   (TAG_W),
        .ADDR_W  (ADDR_W)
    ) u_table (
        .clk       (clk),
        .rst       (rst),
        .rd_idx    (lk_idx),
        .rd_valid  (rd_valid),
        .rd_tag    (rd_tag),
        .rd_prev   (rd_prev),
        .rd_stride (rd_stride),
        .rd_state  (rd_state),
        .wr_en     (ld_valid),
        .wr_idx    (lk_idx),
        .wr_tag    (lk_tag),
        .wr_prev   (nx_prev),
        .wr_stride (nx_stride),
        .wr_state  (nx_state)
    );

    spf_update #(
        .TAG_W  (TAG_W),
        .ADDR_W (ADDR_W)
    ) u_update (
        .lk_tag    (lk_tag),
        .cur_addr  (ld_addr),
        .rd_valid  (rd_valid),
        .rd_tag    (rd_tag),
        .rd_prev   (rd_prev),
        .rd_stride (rd_stride),
        .rd_state  (rd_state),
        .hit       (lk_hit),
        .nx_prev   (nx_prev),
        .nx_stride (nx_stride),
        .nx_state  (nx_state),
        .pf_fire   (pf_fire),
        .pf_target (pf_target)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pf_valid <= 1'b0;
            pf_addr  <= '0;
        end else begin
            pf_valid <= ld_valid && pf_fire;
            if (ld_valid && pf_fire) begin
                pf_addr <= pf_target;
            end
        end
    end

endmodule

// File: rtl/spf_checker.sv
module spf_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              ld_valid,
    input logic [ADDR_W-1:0] ld_addr,
    input logic              lk_hit,
    input logic [ADDR_W-1:0] rd_prev,
    input logic [ADDR_W-1:0] rd_stride,
    input logic              pf_valid,
    input logic [ADDR_W-1:0] pf_addr
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) $past(rst) |-> !pf_valid);

    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !ld_valid |=> !pf_valid);

    // R2
    miss_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (ld_valid && !lk_hit) |=> !pf_valid);

    // R9
    pf_ahead_chk: assert property (@(posedge clk) disable iff (rst)
        pf_valid |-> (pf_addr == $past(ld_addr) + $past(rd_stride)));

    // R3
    pf_confirmed_chk: assert property (@(posedge clk) disable iff (rst)
        pf_valid |-> ($past(ld_addr) - $past(rd_prev) == $past(rd_stride)));

endmodule

bind stride_prefetch_table spf_checker #(.ADDR_W(ADDR_W)) u_spf_chk (
    .clk       (clk),
    .rst       (rst),
    .ld_valid  (ld_valid),
    .ld_addr   (ld_addr),
    .lk_hit    (lk_hit),
    .rd_prev   (rd_prev),
    .rd_stride (rd_stride),
    .pf_valid  (pf_valid),
    .pf_addr   (pf_addr)
);

// File: tb/stride_prefetch_table_test.sv
module stride_prefetch_table_test;

    localparam int PW = 16;
    localparam int AW = 16;
    localparam int NE = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ld_valid = 1'b0;
    logic [PW-1:0] ld_pc = '0;
    logic [AW-1:0] ld_addr = '0;
    logic          pf_valid;
    logic [AW-1:0] pf_addr;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    stride_prefetch_table #(
        .PC_W(PW), .ADDR_W(AW), .ENTRIES(NE), .PC_SKIP(2)
    ) uut (
        .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_pc(ld_pc),
        .ld_addr(ld_addr), .pf_valid(pf_valid), .pf_addr(pf_addr)
    );

    // Table model: 0 Fresh, 1 Tentative, 2 Locked, 3 Silent
    bit          m_val [NE];
    logic [11:0] m_tag [NE];
    logic [AW-1:0] m_prev [NE];
    logic [AW-1:0] m_step [NE];
    int          m_st  [NE];

    task automatic check(string req, bit ok, logic [AW:0] act, logic [AW:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load(string req, logic [PW-1:0] pc, logic [AW-1:0] a);
        int i;
        logic [11:0] t;
        bit ev;
        logic [AW-1:0] ea, obs;
        bit ok;
        i = int'(pc[3:2]);
        t = pc[15:4];
        ev = 0;
        ea = '0;
        if (!m_val[i] || m_tag[i] != t) begin
            m_val[i] = 1; m_tag[i] = t; m_prev[i] = a; m_step[i] = '0; m_st[i] = 0;
        end else begin
            ok  = (a == m_prev[i] + m_step[i]);
            obs = a - m_prev[i];
            case (m_st[i])
                0: begin m_st[i] = ok ? 2 : 1; if (!ok) m_step[i] = obs; end
                1: begin m_st[i] = ok ? 2 : 3; if (!ok) m_step[i] = obs; end
                2: begin m_st[i] = ok ? 2 : 0; end
                default: begin m_st[i] = ok ? 1 : 3; if (!ok) m_step[i] = obs; end
            endcase
            m_prev[i] = a;
            ev = (m_st[i] == 2);
            ea = a + m_step[i];
        end
        @(negedge clk);
        ld_valid = 1'b1; ld_pc = pc; ld_addr = a;
        @(posedge clk);
        #1;
        ld_valid = 1'b0;
        check(req, pf_valid == ev, {16'd0, pf_valid}, {16'd0, ev});
        if (ev) check(req, pf_addr == ea, {1'b0, pf_addr}, {1'b0, ea});
    endtask

    task automatic idle(string req);
        @(negedge clk);
        ld_valid = 1'b0;
        @(posedge clk);
        #1;
        check(req, pf_valid == 1'b0, {16'd0, pf_valid}, 17'd0);
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        logic [AW-1:0] cur [8];
        logic [AW-1:0] stp [8];
        for (int i = 0; i < NE; i++) begin m_val[i] = 0; m_st[i] = 0; end
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", pf_valid == 1'b0, {16'd0, pf_valid}, 17'd0);
        @(negedge clk);
        rst = 1'b0;

        // R1 / R2: first load is a miss
        load("R2 miss allocates", 16'h0040, 16'd100);
        // R4: Fresh wrong -> Tentative, step 4
        load("R4 fresh wrong", 16'h0040, 16'd104);
        // R5: Tentative correct -> Locked, request 112
        load("R5 tentative correct", 16'h0040, 16'd108);
        idle("R9 one-cycle pulse");
        // R12: state survives idles
        idle("R12 idle");
        idle("R12 idle");
        load("R6 locked correct", 16'h0040, 16'd112);
        // R6: Locked wrong -> Fresh, step 4 kept
        load("R6 locked wrong", 16'h0040, 16'd200);
        // R8/R6: last address 200, kept step 4 -> correct -> Locked, req 208
        load("R8 R6 step kept", 16'h0040, 16'd204);
        // R7: walk into Silent and out
        load("R6 leave lock", 16'h0040, 16'd300);
        load("R4 fresh relearn", 16'h0040, 16'd310);
        load("R5 tentative wrong", 16'h0040, 16'd330);
        load("R7 silent wrong", 16'h0040, 16'd340);
        load("R7 silent correct", 16'h0040, 16'd350);
        load("R7 back to lock", 16'h0040, 16'd360);
        // R10: descending and wrapping
        load("R10 desc", 16'h0104, 16'd1000);
        load("R10 desc", 16'h0104, 16'd992);
        load("R10 desc", 16'h0104, 16'd984);
        load("R10 wrap", 16'h0108, 16'h0008);
        load("R10 wrap", 16'h0108, 16'h0004);
        load("R10 wrap", 16'h0108, 16'h0000);
        load("R10 wrap", 16'h0108, 16'hFFFC);
        // R11: alias on slot 0 evicts
        load("R11 alias miss", 16'h0090, 16'd364);
        load("R11 evicted", 16'h0040, 16'd370);
        load("R11 evicted", 16'h0040, 16'd380);
        // R3: step equality is modulo; correct after relearn
        load("R3 correct", 16'h0040, 16'd390);

        // Mixed pseudo-random phase against the model
        lf = 16'hACE1;
        for (int s = 0; s < 8; s++) begin
            cur[s] = AW'(s * 16'h1000);
            stp[s] = AW'(4 * (s + 1));
        end
        for (int n = 0; n < 4000; n++) begin
            int s;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            s = int'(lf[2:0]);
            if (lf[7:4] == 4'd0) stp[s] = AW'(signed'({{12{lf[11]}}, lf[11:8]}) * 4);
            if (lf[15:13] == 3'd0) cur[s] = cur[s] + 16'h0777;
            cur[s] = cur[s] + stp[s];
            if (lf[12:10] == 3'd7) idle("R12 random idle");
            else load("R3 R9 R11 random", {11'd0, s[2], 1'b0, s[1:0], 2'b00}, cur[s]);
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule